// File: doc/BRIEF.md
# Instruction Decoder with Branch Evaluation

This block takes one 16-bit instruction word for an eight-register machine and splits it into the signals a datapath needs. It reports the instruction format, the three register indices, the ALU operation code and an immediate that is already sign-extended or shifted. It also drives a memory read or write strobe and a return-address write request. For conditional branches it checks the current condition flags and raises a branch-taken signal.

The decode logic is combinational. With the default `REG_OUT = 1`, every output passes through one register stage with a synchronous active-low reset. The result for an instruction presented before a rising edge is therefore visible after that edge. With `REG_OUT = 0` the outputs follow the inputs directly.

The block has no state machine. The format field selects one of eight decode paths: ARITH, LOAD, STORE, ADDI, LUI, BCOND, BRANCH and JREG. The only sequencing is the optional output stage, which moves between two conditions. It is held in RESET while `rst_n` is low, and moves to RUN on the first rising edge with `rst_n` high.

Top module: `insn_decode_unit`

## Requirements
- R1: `fmt_o` equals instruction bits 15:13, coded 0 ARITH, 1 LOAD, 2 STORE, 3 ADDI, 4 LUI, 5 BCOND, 6 BRANCH, 7 JREG. `mem_rd_o` is 1 only for LOAD and `mem_wr_o` is 1 only for STORE.
- R2: `rd_o` is bits 2:0, `ra_o` is bits 5:3 and `rb_o` is bits 8:6, for every format. `alu_op_o` is bits 12:9 for ARITH and 0 for every other format.
- R3: For LOAD and ADDI, `imm_o` is bits 12:6 sign-extended from bit 12 to 16 bits.
- R4: For STORE, `imm_o` is the 7-bit value {bits 12:9, bits 2:0} sign-extended from bit 12.
- R5: For LUI, `imm_o` is bits 12:3 placed in bits 15:6, with bits 5:0 zero.
- R6: For BCOND, `imm_o` is bits 9:0 sign-extended. The condition is bits 12:10. Its low two bits pick a flag from `flags_i`: 0 Z (bit 0), 1 N (bit 1), 2 C (bit 2), 3 O (bit 3). `taken_o` is that flag when condition bit 2 is 0, and its inverse when condition bit 2 is 1. `link_o` is 0.
- R7: For BRANCH, `imm_o` is bits 11:0 sign-extended, `taken_o` is 1 and `link_o` is bit 12.
- R8: For JREG, `taken_o` is 1, `link_o` is bit 12, the target register appears on `ra_o` and `imm_o` is 0.
- R9: For ARITH, `imm_o`, `taken_o`, `link_o` and both strobes are 0.
- R10: With `REG_OUT = 1`, outputs show the decode of the inputs sampled at the previous rising edge. A rising edge with `rst_n` low sets every output to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output stage |
| rst_n | input | 1 | Synchronous active-low reset of the output stage |
| insn_i | input | 16 | Instruction word |
| flags_i | input | 4 | Condition flags: bit 0 Z, 1 N, 2 C, 3 O |
| fmt_o | output | 3 | Instruction format code |
| alu_op_o | output | 4 | ALU operation (ARITH only) |
| rd_o | output | 3 | Destination register index |
| ra_o | output | 3 | First source, pointer or jump target index |
| rb_o | output | 3 | Second source or store data index |
| imm_o | output | 16 | Extended immediate or offset |
| mem_rd_o | output | 1 | Memory read strobe |
| mem_wr_o | output | 1 | Memory write strobe |
| link_o | output | 1 | Return-address write to r7 |
| taken_o | output | 1 | Branch or jump taken |

## Verification
The bench runs all eight branch conditions against flag words where only the selected flag differs. A design that swaps the set and clear senses, or picks the wrong flag, then gives the wrong taken value. It also drives store offsets whose high and low parts are all ones or all zeros. A design that misplaces the split fields or extends from the wrong bit then shows a wrong upper byte. Offsets at the largest positive and most negative values expose sign extension taken from the wrong width. A stream of pseudo-random words then checks that ALU code, link, strobes and immediate stay zero in every format that does not define them.

// File: rtl/idu_pkg.sv
package idu_pkg;

    typedef enum logic [2:0] {
        F_ARITH  = 3'd0,
        F_LOAD   = 3'd1,
        F_STORE  = 3'd2,
        F_ADDI   = 3'd3,
        F_LUI    = 3'd4,
        F_BCOND  = 3'd5,
        F_BRANCH = 3'd6,
        F_JREG   = 3'd7
    } fmt_e;

    localparam int INSN_W = 16;
    localparam int FLAG_W = 4;
    localparam int LUI_W  = 10;

endpackage

// File: rtl/idu_imm_gen.sv
module idu_imm_gen
    import idu_pkg::*;
#(
    parameter int XLEN = 16
) (
    input  fmt_e                    fmt,
    input  logic [INSN_W-1:0]       insn,
    output logic [XLEN-1:0]         imm
);
    localparam int MEM_W = 7;
    localparam int BC_W  = 10;
    localparam int BR_W  = 12;

    logic [MEM_W-1:0] ld_field;
    logic [MEM_W-1:0] st_field;
    logic [BC_W-1:0]  bc_field;
    logic [BR_W-1:0]  br_field;

    always_comb begin
        ld_field = insn[12:6];
        st_field = {insn[12:9], insn[2:0]};
        bc_field = insn[9:0];
        br_field = insn[11:0];
    end

    always_comb begin
        imm = '0;
        unique case (fmt)
            F_LOAD, F_ADDI: imm = {{(XLEN-MEM_W){ld_field[MEM_W-1]}}, ld_field};
            F_STORE:        imm = {{(XLEN-MEM_W){st_field[MEM_W-1]}}, st_field};
            F_LUI:          imm[XLEN-1 -: LUI_W] = insn[12:3];
            F_BCOND:        imm = {{(XLEN-BC_W){bc_field[BC_W-1]}}, bc_field};
            F_BRANCH:       imm = {{(XLEN-BR_W){br_field[BR_W-1]}}, br_field};
            F_ARITH, F_JREG: imm = '0;
            default:        imm = '0;
        endcase
    end
endmodule

// File: rtl/idu_branch_eval.sv
module idu_branch_eval
    import idu_pkg::*;
(
    input  fmt_e              fmt,
    input  logic [2:0]        cond,
    input  logic [FLAG_W-1:0] flags,
    output logic              taken
);
    logic picked;

    always_comb begin
        picked = flags[cond[1:0]];
        unique case (fmt)
            F_BCOND:         taken = picked ^ cond[2];
            F_BRANCH, F_JREG: taken = 1'b1;
            default:         taken = 1'b0;
        endcase
    end
endmodule

// File: rtl/insn_decode_unit.sv
module insn_decode_unit
    import idu_pkg::*;
#(
    parameter int XLEN    = 16,
    parameter int RIDX    = 3,
    parameter bit REG_OUT = 1'b1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [INSN_W-1:0]    insn_i,
    input  logic [FLAG_W-1:0]    flags_i,
    output logic [2:0]           fmt_o,
    output logic [3:0]           alu_op_o,
    output logic [RIDX-1:0]      rd_o,
    output logic [RIDX-1:0]      ra_o,
    output logic [RIDX-1:0]      rb_o,
    output logic [XLEN-1:0]      imm_o,
    output logic                 mem_rd_o,
    output logic                 mem_wr_o,
    output logic                 link_o,
    output logic                 taken_o
);
    localparam int OUT_W = 3 + 4 + 3*RIDX + XLEN + 4;

    fmt_e            fmt;
    logic [3:0]      alu_op;
    logic [XLEN-1:0] imm;
    logic            taken;
    logic            link;
    logic            mrd;
    logic            mwr;
    logic [OUT_W-1:0] dec_vec;
    logic [OUT_W-1:0] out_vec;

    always_comb begin
        fmt    = fmt_e'(insn_i[15:13]);
        alu_op = 4'd0;
        link   = 1'b0;
        mrd    = 1'b0;
        mwr    = 1'b0;
        unique case (fmt)
            F_ARITH:          alu_op = insn_i[12:9];
            F_LOAD:           mrd = 1'b1;
            F_STORE:          mwr = 1'b1;
            F_BRANCH, F_JREG: link = insn_i[12];
            default:          ;
        endcase
    end

    idu_imm_gen #(.XLEN(XLEN)) u_imm (
        .fmt  (fmt),
        .insn (insn_i),
        .imm  (imm)
    );

    idu_branch_eval u_br (
        .fmt   (fmt),
        .cond  (insn_i[12:10]),
        .flags (flags_i),
        .taken (taken)
    );

    assign dec_vec = {fmt, alu_op, insn_i[2:0], insn_i[5:3], insn_i[8:6],
                      imm, mrd, mwr, link, taken};

    generate
        if (REG_OUT) begin : g_reg
            always_ff @(posedge clk) begin
                if (!rst_n) out_vec <= '0;
                else        out_vec <= dec_vec;
            end

            // R10: reset clears the stage
            a_r10_reset_clear: assert property (@(posedge clk)
                !rst_n |=> (out_vec == '0));
            // R1: load raises only the read strobe
            a_r1_load_strobe: assert property (@(posedge clk) disable iff (!rst_n)
                (insn_i[15:13] == 3'd1) |=> (mem_rd_o && !mem_wr_o));
            // R5: low six bits cleared for LUI
            a_r5_lui_low: assert property (@(posedge clk) disable iff (!rst_n)
                (insn_i[15:13] == 3'd4) |=> (imm_o[5:0] == 6'd0));
            // R7: branch and jump always taken, link follows bit 12
            a_r7_uncond_taken: assert property (@(posedge clk) disable iff (!rst_n)
                (insn_i[15:14] == 2'b11) |=> (taken_o && (link_o == $past(insn_i[12]))));
            // R6: zero-flag conditions
            a_r6_zero_cond: assert property (@(posedge clk) disable iff (!rst_n)
                (insn_i[15:13] == 3'd5 && insn_i[11:10] == 2'd0)
                |=> (taken_o == ($past(flags_i[0]) ^ $past(insn_i[12]))));
            // R9: arithmetic is quiet on control outputs
            a_r9_arith_quiet: assert property (@(posedge clk) disable iff (!rst_n)
                (insn_i[15:13] == 3'd0)
                |=> (!taken_o && !link_o && !mem_rd_o && !mem_wr_o && imm_o == '0));
        end else begin : g_comb
            assign out_vec = dec_vec;
        end
    endgenerate

    assign {fmt_o, alu_op_o, rd_o, ra_o, rb_o, imm_o,
            mem_rd_o, mem_wr_o, link_o, taken_o} = out_vec;

endmodule

// File: tb/insn_decode_unit_tb.sv
module insn_decode_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] insn_i = '0;
    logic [3:0]  flags_i = '0;
    logic [2:0]  fmt_o;
    logic [3:0]  alu_op_o;
    logic [2:0]  rd_o, ra_o, rb_o;
    logic [15:0] imm_o;
    logic        mem_rd_o, mem_wr_o, link_o, taken_o;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #4 clk = ~clk;

    insn_decode_unit dut_i (
        .clk(clk), .rst_n(rst_n), .insn_i(insn_i), .flags_i(flags_i),
        .fmt_o(fmt_o), .alu_op_o(alu_op_o), .rd_o(rd_o), .ra_o(ra_o),
        .rb_o(rb_o), .imm_o(imm_o), .mem_rd_o(mem_rd_o), .mem_wr_o(mem_wr_o),
        .link_o(link_o), .taken_o(taken_o)
    );

    function automatic logic [15:0] sx(input int v, input int bits);
        int r = v;
        if (r >= (1 << (bits - 1))) r = r - (1 << bits);
        return 16'(r);
    endfunction

    function automatic logic [35:0] model(input logic [15:0] w, input logic [3:0] fl);
        int f = int'(w[15:13]);
        logic [3:0]  op = 0;
        logic [15:0] im = 0;
        logic rd = 0, wr = 0, lk = 0, tk = 0;
        case (f)
            0: op = w[12:9];
            1: begin rd = 1; im = sx(int'(w[12:6]), 7); end
            2: begin wr = 1; im = sx(int'(w[12:9]) * 8 + int'(w[2:0]), 7); end
            3: im = sx(int'(w[12:6]), 7);
            4: im = 16'(int'(w[12:3]) * 64);
            5: begin
                im = sx(int'(w[9:0]), 10);
                case (int'(w[12:10]))
                    0: tk = fl[0];
                    1: tk = fl[1];
                    2: tk = fl[2];
                    3: tk = fl[3];
                    4: tk = !fl[0];
                    5: tk = !fl[1];
                    6: tk = !fl[2];
                    default: tk = !fl[3];
                endcase
            end
            6: begin tk = 1; lk = w[12]; im = sx(int'(w[11:0]), 12); end
            default: begin tk = 1; lk = w[12]; end
        endcase
        return {w[15:13], op, w[2:0], w[5:3], w[8:6], im, rd, wr, lk, tk};
    endfunction

    function automatic string tag(input logic [15:0] w);
        case (int'(w[15:13]))
            0: return "R9/R2";
            1: return "R3/R1";
            2: return "R4/R1";
            3: return "R3";
            4: return "R5";
            5: return "R6";
            6: return "R7";
            default: return "R8";
        endcase
    endfunction

    function automatic logic [35:0] got();
        return {fmt_o, alu_op_o, rd_o, ra_o, rb_o, imm_o, mem_rd_o, mem_wr_o, link_o, taken_o};
    endfunction

    task automatic step(input logic [15:0] w, input logic [3:0] fl);
        logic [35:0] e;
        @(negedge clk);
        insn_i = w;
        flags_i = fl;
        e = model(w, fl);
        @(posedge clk);
        #2;
        total++;
        if (got() !== e) begin
            bad++;
            $display("FAIL %s insn=%h flags=%b actual=%h expected=%h R10", tag(w), w, fl, got(), e);
        end
    endtask

    initial begin
        logic [15:0] lf;
        insn_i = 16'hDFFF;
        flags_i = 4'hF;
        repeat (3) @(posedge clk);
        #2;
        total++;
        if (got() !== 36'd0) begin
            bad++;
            $display("FAIL R10 reset actual=%h expected=0", got());
        end
        @(negedge clk);
        rst_n = 1'b1;
        // R9 R2 arithmetic
        step(16'h0000, 4'h0);
        step(16'h1FFF, 4'hF);
        step(16'h0B5A, 4'h3);
        // R3 load and addi at extremes
        step(16'h2FFF, 4'h0);
        step(16'h3000, 4'h0);
        step(16'h6FC0, 4'h0);
        step(16'h703F, 4'h0);
        // R4 store split offset
        step(16'h5E07, 4'h0);
        step(16'h4000, 4'h0);
        step(16'h5FF8, 4'h0);
        step(16'h4007, 4'h0);
        // R5 lui
        step(16'h9FFF, 4'h0);
        step(16'h8008, 4'h0);
        // R6 every condition against every single-flag word
        for (int c = 0; c < 8; c++)
            for (int fl = 0; fl < 16; fl++)
                step(16'hA000 | 16'(c << 10) | 16'h0200, 4'(fl));
        step(16'hA1FF, 4'h0);
        // R7 branch, link clear and set
        step(16'hC800, 4'h0);
        step(16'hD7FF, 4'h0);
        // R8 jump to register
        step(16'hE038, 4'h0);
        step(16'hF028, 4'hF);
        // mixed stream
        lf = 16'hACE1;
        for (int i = 0; i < 400; i++) begin
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            step(lf, lf[7:4]);
        end
        // R10 reset after activity
        @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk);
        #2;
        total++;
        if (got() !== 36'd0) begin
            bad++;
            $display("FAIL R10 re-reset actual=%h expected=0", got());
        end
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(8 * 100000);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired R10 actual=hung expected=finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule